// File: doc/BRIEF.md
# Deferred-Start Counter Channel

This block is one 16-bit counter channel whose start is aligned to a slow count-clock enable pulse rather than to the moment software asks for it. A start strobe raises the enabled flag at once and arms a pending start. Nothing happens to the counter until the next count-clock pulse arrives. That pulse performs the initial load and does not count. Every later pulse advances the counter according to the selected mode. Because of this, the first period can run up to one count-clock period longer than programmed.

Three modes are available. In the periodic mode the counter counts down from the reload value and reloads itself after reaching zero. In the single-shot mode it counts down once and then rests at zero. In the measuring mode it counts up from zero until a rising edge on the capture input stores the count. An option raises the interrupt pulse on the loading tick, so software can see exactly when counting began. A stop strobe halts the channel and freezes the count.

Top module: `deferred_start_timer`

## Requirements
- R1: After reset the count, capture value, enabled flag, pending flag and interrupt are all 0.
- R2: A start strobe without stop sets the enabled and pending flags on the next cycle. While the start is pending the count keeps its previous value.
- R3: The first count-clock pulse while pending clears the pending flag and loads the count. The load value is the reload input when mode_i is 0 (periodic) or 1 (single-shot), and 0 when mode_i is 2 (measuring); mode_i 3 acts as periodic. No counting takes place on that pulse.
- R4: On the loading pulse, irq_o pulses for one cycle exactly when irq_at_start_i is 1.
- R5: Periodic mode: each count-clock pulse decrements the count. A pulse that finds the count at 0 reloads the count from the reload input and raises irq_o for one cycle.
- R6: Single-shot mode: each pulse decrements the count. A pulse that finds the count at 0 raises irq_o, and the count then stays at 0 until a new start.
- R7: Measuring mode: each pulse increments the count. A rising edge on capture_i copies the count to capture_o, raises irq_o and halts counting. If the edge and a pulse arrive in the same cycle, the edge wins.
- R8: A stop strobe clears the enabled and pending flags on the next cycle and freezes the count. Stop wins over a simultaneous start.
- R9: In a cycle with no count-clock pulse the count does not change.
- R10: Outside measuring mode, edges on capture_i leave capture_o unchanged and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick_i | input | 1 | Count-clock enable pulse, one clk cycle wide |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| mode_i | input | 2 | 0 periodic, 1 single-shot, 2 measuring |
| reload_i | input | 16 | Reload data |
| irq_at_start_i | input | 1 | Raise the interrupt on the loading pulse |
| capture_i | input | 1 | Capture input, rising edge active |
| count_o | output | 16 | Counter value |
| enabled_o | output | 1 | Channel enabled |
| pending_o | output | 1 | Start waiting for count clock |
| irq_o | output | 1 | One-cycle interrupt pulse |
| capture_o | output | 16 | Last captured count |

## Verification
The assertions take for granted that mode and reload data hold steady across the loading pulse, and that the count-clock enable is a single-cycle pulse. They also assume a new start is not issued in the same cycle as the pulse that consumes a pending one. The stimulus keeps to these conditions by changing mode and reload only while the channel is stopped, and by issuing starts only in cycles without a tick. Its edges on capture_i are separated by at least one low cycle.

// File: rtl/dst_pkg.sv
package dst_pkg;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_SINGLE   = 2'd1,
        MODE_MEASURE  = 2'd2,
        MODE_SPARE    = 2'd3
    } dst_mode_e;

    typedef struct packed {
        logic enabled;
        logic pending;
    } dst_ctrl_t;

endpackage

// File: rtl/dst_capture_edge.sv
module dst_capture_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/dst_start_ctrl.sv
module dst_start_ctrl
    import dst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic enabled_o,
    output logic pending_o,
    output logic load_o
);
    dst_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        load_o = ctrl_q.pending & tick_i & ~stop_i;
        if (stop_i) begin
            ctrl_d.enabled = 1'b0;
            ctrl_d.pending = 1'b0;
        end else if (start_i) begin
            ctrl_d.enabled = 1'b1;
            ctrl_d.pending = 1'b1;
        end else if (load_o) begin
            ctrl_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign enabled_o = ctrl_q.enabled;
    assign pending_o = ctrl_q.pending;

    assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!enabled_o && !pending_o));

    assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (enabled_o && pending_o));
endmodule

// File: rtl/dst_count_core.sv
module dst_count_core
    import dst_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic             stop_i,
    input  logic             pending_i,
    input  dst_mode_e        mode_i,
    input  logic [WIDTH-1:0] reload_i,
    input  logic             irq_at_start_i,
    input  logic             cap_rise_i,
    output logic [WIDTH-1:0] count_o,
    output logic             irq_o,
    output logic [WIDTH-1:0] capture_o
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic [WIDTH-1:0] capt;
        dst_mode_e        mode;
        logic             run;
        logic             irq;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.irq = 1'b0;
        if (stop_i) begin
            core_d.run = 1'b0;
        end else if (load_i) begin
            core_d.mode  = mode_i;
            core_d.count = (mode_i == MODE_MEASURE) ? ZERO : reload_i;
            core_d.run   = 1'b1;
            core_d.irq   = irq_at_start_i;
        end else if (core_q.run) begin
            if (core_q.mode == MODE_MEASURE && cap_rise_i) begin
                core_d.capt = core_q.count;
                core_d.irq  = 1'b1;
                core_d.run  = 1'b0;
            end else if (tick_i) begin
                case (core_q.mode)
                    MODE_SINGLE: begin
                        if (core_q.count == ZERO) begin
                            core_d.irq = 1'b1;
                            core_d.run = 1'b0;
                        end else begin
                            core_d.count = core_q.count - ONE;
                        end
                    end
                    MODE_MEASURE: core_d.count = core_q.count + ONE;
                    default: begin
                        if (core_q.count == ZERO) begin
                            core_d.count = reload_i;
                            core_d.irq   = 1'b1;
                        end else begin
                            core_d.count = core_q.count - ONE;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{count: ZERO, capt: ZERO, mode: MODE_PERIODIC, run: 1'b0, irq: 1'b0};
        else        core_q <= core_d;
    end

    assign count_o   = core_q.count;
    assign irq_o     = core_q.irq;
    assign capture_o = core_q.capt;

    assert_pending_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i && !tick_i) |=> $stable(count_o));

    assert_load_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i == MODE_MEASURE) |=> (count_o == ZERO));

    assert_load_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i != MODE_MEASURE) |=> (count_o == $past(reload_i)));

    assert_irq_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (irq_o == $past(irq_at_start_i)));

    assert_halted_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_q.run && !load_i) |=> $stable(count_o));

    assert_capture_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(capture_o) |-> irq_o);
endmodule

// File: rtl/deferred_start_timer.sv
module deferred_start_timer
    import dst_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] reload_i,
    input  logic             irq_at_start_i,
    input  logic             capture_i,
    output logic [WIDTH-1:0] count_o,
    output logic             enabled_o,
    output logic             pending_o,
    output logic             irq_o,
    output logic [WIDTH-1:0] capture_o
);
    logic load_w;
    logic cap_rise_w;

    dst_start_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .tick_i    (cnt_tick_i),
        .enabled_o (enabled_o),
        .pending_o (pending_o),
        .load_o    (load_w)
    );

    dst_capture_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (capture_i),
        .rise_o (cap_rise_w)
    );

    dst_count_core #(.WIDTH(WIDTH)) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (cnt_tick_i),
        .load_i         (load_w),
        .stop_i         (stop_i),
        .pending_i      (pending_o),
        .mode_i         (dst_mode_e'(mode_i)),
        .reload_i       (reload_i),
        .irq_at_start_i (irq_at_start_i),
        .cap_rise_i     (cap_rise_w),
        .count_o        (count_o),
        .irq_o          (irq_o),
        .capture_o      (capture_o)
    );

    assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick_i |=> $stable(count_o));
endmodule

// File: tb/tb_deferred_start_timer.sv
module tb_deferred_start_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick_i = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [15:0] reload_i = 16'd0;
    logic        irq_at_start_i = 1'b0;
    logic        capture_i = 1'b0;
    logic [15:0] count_o;
    logic        enabled_o;
    logic        pending_o;
    logic        irq_o;
    logic [15:0] capture_o;

    deferred_start_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick_i(cnt_tick_i), .start_i(start_i),
        .stop_i(stop_i), .mode_i(mode_i), .reload_i(reload_i),
        .irq_at_start_i(irq_at_start_i), .capture_i(capture_i),
        .count_o(count_o), .enabled_o(enabled_o), .pending_o(pending_o),
        .irq_o(irq_o), .capture_o(capture_o)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        logic [15:0] cnt;
        logic        en;
        logic        pend;
        logic        irq;
        logic [15:0] capv;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;

    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
            mon_e = sb_q.pop_front();
            checks++;
            if (count_o !== mon_e.cnt || enabled_o !== mon_e.en || pending_o !== mon_e.pend ||
                irq_o !== mon_e.irq || capture_o !== mon_e.capv) begin
                errors++;
                $display("FAIL %s cyc %0d: got cnt=%0h en=%b pend=%b irq=%b cap=%0h exp cnt=%0h en=%b pend=%b irq=%b cap=%0h",
                         mon_e.tag, cyc, count_o, enabled_o, pending_o, irq_o, capture_o,
                         mon_e.cnt, mon_e.en, mon_e.pend, mon_e.irq, mon_e.capv);
            end
        end
    end

    task automatic step(input logic st, input logic sp, input logic tk, input logic cp,
                        input logic [15:0] e_cnt, input logic e_en, input logic e_pend,
                        input logic e_irq, input logic [15:0] e_cap, input string tag);
        exp_t e;
        start_i    = st;
        stop_i     = sp;
        cnt_tick_i = tk;
        capture_i  = cp;
        e.at = cyc + 1; e.cnt = e_cnt; e.en = e_en; e.pend = e_pend;
        e.irq = e_irq; e.capv = e_cap; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0,0,0,0, 16'd0,0,0,0,16'd0, "R1 reset state");

        // periodic mode, reload 3, no start interrupt
        mode_i = 2'd0; reload_i = 16'd3; irq_at_start_i = 1'b0;
        step(1,0,0,0, 16'd0,1,1,0,16'd0, "R2 start arms");
        step(0,0,0,0, 16'd0,1,1,0,16'd0, "R2 pending holds count");
        step(0,0,1,0, 16'd3,1,0,0,16'd0, "R3 R4 load reload, no irq");
        step(0,0,1,0, 16'd2,1,0,0,16'd0, "R5 decrement");
        step(0,0,1,0, 16'd1,1,0,0,16'd0, "R5 decrement");
        step(0,0,1,0, 16'd0,1,0,0,16'd0, "R5 reach zero");
        step(0,0,1,0, 16'd3,1,0,1,16'd0, "R5 reload with irq");
        step(0,0,0,0, 16'd3,1,0,0,16'd0, "R9 no tick holds, irq one cycle");
        step(0,0,1,0, 16'd2,1,0,0,16'd0, "R5 decrement after reload");
        step(0,1,0,0, 16'd2,0,0,0,16'd0, "R8 stop clears enabled");
        step(0,0,1,0, 16'd2,0,0,0,16'd0, "R8 count frozen after stop");

        // single-shot mode, reload 2, interrupt at start
        mode_i = 2'd1; reload_i = 16'd2; irq_at_start_i = 1'b1;
        step(1,0,0,0, 16'd2,1,1,0,16'd0, "R2 start keeps old count");
        step(0,0,1,0, 16'd2,1,0,1,16'd0, "R3 R4 load with start irq");
        step(0,0,1,0, 16'd1,1,0,0,16'd0, "R6 decrement");
        step(0,0,1,0, 16'd0,1,0,0,16'd0, "R6 reach zero");
        step(0,0,1,0, 16'd0,1,0,1,16'd0, "R6 irq at zero");
        step(0,0,1,0, 16'd0,1,0,0,16'd0, "R6 holds zero");
        step(0,0,1,0, 16'd0,1,0,0,16'd0, "R6 holds zero");
        step(0,0,0,1, 16'd0,1,0,0,16'd0, "R10 capture edge ignored");
        step(0,0,0,0, 16'd0,1,0,0,16'd0, "R10 capture unchanged");
        step(1,0,0,0, 16'd0,1,1,0,16'd0, "R6 restart arms");
        step(0,0,1,0, 16'd2,1,0,1,16'd0, "R6 restart reloads");
        step(1,1,0,0, 16'd2,0,0,0,16'd0, "R8 stop beats start");
        step(0,0,1,0, 16'd2,0,0,0,16'd0, "R8 no counting after stop");

        // measuring mode, interrupt at start off
        mode_i = 2'd2; reload_i = 16'd9; irq_at_start_i = 1'b0;
        step(1,0,0,0, 16'd2,1,1,0,16'd0, "R2 start arms");
        step(0,0,1,0, 16'd0,1,0,0,16'd0, "R3 load zero");
        step(0,0,1,0, 16'd1,1,0,0,16'd0, "R7 increment");
        step(0,0,1,0, 16'd2,1,0,0,16'd0, "R7 increment");
        step(0,0,1,0, 16'd3,1,0,0,16'd0, "R7 increment");
        step(0,0,0,1, 16'd3,1,0,1,16'd3, "R7 capture edge");
        step(0,0,1,1, 16'd3,1,0,0,16'd3, "R7 halted, level not edge");
        step(0,0,1,0, 16'd3,1,0,0,16'd3, "R7 stays halted");
        step(1,0,0,0, 16'd3,1,1,0,16'd3, "R2 rearm");
        step(0,0,1,0, 16'd0,1,0,0,16'd3, "R3 load zero again");
        step(0,0,1,0, 16'd1,1,0,0,16'd3, "R7 increment");
        step(0,0,1,1, 16'd1,1,0,1,16'd1, "R7 edge beats tick");
        step(0,0,0,0, 16'd1,1,0,0,16'd1, "R7 irq one cycle");
        step(1,0,0,0, 16'd1,1,1,0,16'd1, "R2 arm before stop");
        step(0,1,0,0, 16'd1,0,0,0,16'd1, "R8 stop clears pending");
        step(0,0,1,0, 16'd1,0,0,0,16'd1, "R8 tick does not load");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items never compared", sb_q.size());
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule